// File: doc/BRIEF.md
# Multi-Width Unsigned Divider

This block is a sequential unsigned divider. It divides a double-width dividend by a single-width divisor and returns a single-width quotient and remainder. The operand width is chosen per operation: 8, 16 or 32 bits. The dividend arrives as two halves, an upper half and a lower half, each as wide as the chosen operand size. Input bits above that size are ignored. The quotient and remainder are returned zero-extended on 32-bit outputs.

An operation starts with a one-cycle `start` strobe while the block is idle. Before any iteration begins, the block compares the dividend's upper half with the divisor. If the upper half is equal to or greater than the divisor, the quotient cannot fit in the output width, and a zero divisor always fails this test. In that case the block signals a divide-error at once and leaves its result registers unchanged.

Otherwise the block computes one quotient bit per clock by restoring shift-subtract. A fixed setup delay is added so that the latency matches the required 14, 22 or 38 clocks. `done` pulses for one cycle when the result is ready.

Top module: `udiv_multi`

## Requirements
- R1: With size code 0, the dividend is {dvd_hi[7:0], dvd_lo[7:0]} and the divisor is divisor[7:0]. The quotient appears in quotient[7:0] and the remainder in remainder[7:0], and the upper bits of both outputs are zero.
- R2: With size code 1, the dividend is {dvd_hi[15:0], dvd_lo[15:0]} and the divisor is divisor[15:0], giving a 16-bit quotient and a 16-bit remainder, each zero-extended.
- R3: With size code 2 or 3, the dividend is the 64-bit value {dvd_hi, dvd_lo} and the divisor is the full 32-bit divisor, giving a 32-bit quotient and a 32-bit remainder.
- R4: A divisor whose in-size bits are all zero causes a divide-error.
- R5: A divide-error is raised exactly when the true quotient exceeds the in-size maximum. This happens when the in-size upper dividend half is greater than or equal to the in-size divisor. An upper half of divisor minus one does not cause an error.
- R6: On a divide-error, `done` and `err` are high in the cycle after the start edge, `busy` is never raised, and the quotient and remainder keep their previous values.
- R7: On success, the remainder is strictly less than the divisor, and quotient × divisor + remainder equals the dividend.
- R8: On success, `busy` is high from the cycle after the start edge, and `done` goes high after 14, 22 or 38 rising edges counted from and including the start edge, for byte, word and dword sizes. `busy` is low whenever `done` is high.
- R9: A `start` strobe that arrives while `busy` is high is ignored: the running result is unchanged, and no extra `done` follows it.
- R10: `done` is high for a single cycle per operation, and `err` is high only together with `done`.
- R11: After reset, `busy`, `done` and `err` are low, and the quotient and remainder are zero.
- R12: Input bits above the selected size, in dvd_hi, dvd_lo and divisor, have no effect on the result or on error detection.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| size_sel | input | 2 | Operand size: 0 byte, 1 word, 2 or 3 dword |
| dvd_hi | input | 32 | Upper dividend half |
| dvd_lo | input | 32 | Lower dividend half |
| divisor | input | 32 | Divisor |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Divide-error, valid with done |
| quotient | output | 32 | Zero-extended quotient |
| remainder | output | 32 | Zero-extended remainder |

## Verification
The bench targets the overflow boundary on each size, where the upper half equals the divisor or is one less than it. A wrong comparison there either drops a quotient bit silently or raises a false error.

It drives divisors that are zero only within the selected size, along with junk upper input bits. A design that reads the full 32 bits would then miss the error or return a wrong quotient.

It also checks three other behaviours:
- The exact completion cycle for each size. An off-by-one iteration count shows up as a latency or quotient mismatch.
- That the previous results survive a divide-error.
- That a strobe arriving mid-operation neither corrupts the running result nor starts a second one.

// File: rtl/udiv_pkg.sv
package udiv_pkg;
    typedef enum logic [1:0] {
        SZ_BYTE  = 2'd0,
        SZ_WORD  = 2'd1,
        SZ_DWORD = 2'd2,
        SZ_WIDE  = 2'd3
    } size_e;

    localparam int unsigned BYTE_W  = 8;
    localparam int unsigned WORD_W  = 16;
    localparam int unsigned DWORD_W = 32;

    function automatic int unsigned size_width(size_e s);
        case (s)
            SZ_BYTE: return BYTE_W;
            SZ_WORD: return WORD_W;
            default: return DWORD_W;
        endcase
    endfunction
endpackage

// File: rtl/udiv_operand.sv
// Selects the in-size slice of each operand and zero-extends it.
module udiv_operand
    import udiv_pkg::*;
#(
    parameter int unsigned MAX_W = 32
) (
    input  size_e             sz,
    input  logic [MAX_W-1:0]  hi_in,
    input  logic [MAX_W-1:0]  lo_in,
    input  logic [MAX_W-1:0]  dv_in,
    output logic [MAX_W-1:0]  hi_out,
    output logic [MAX_W-1:0]  lo_out,
    output logic [MAX_W-1:0]  dv_out
);
    logic [MAX_W-1:0] mask;

    always_comb begin
        mask   = {MAX_W{1'b1}} >> (MAX_W - size_width(sz));
        hi_out = hi_in & mask;
        lo_out = lo_in & mask;
        dv_out = dv_in & mask;
    end
endmodule

// File: rtl/udiv_ovf.sv
// Quotient-overflow test; a zero divisor always trips it.
module udiv_ovf #(
    parameter int unsigned MAX_W = 32
) (
    input  logic [MAX_W-1:0] hi,
    input  logic [MAX_W-1:0] dv,
    output logic             ovf
);
    assign ovf = (hi >= dv);
endmodule

// File: rtl/udiv_step.sv
// One restoring shift-subtract step: needs rem_in < dv.
module udiv_step #(
    parameter int unsigned MAX_W = 32
) (
    input  logic [MAX_W-1:0] rem_in,
    input  logic             bit_in,
    input  logic [MAX_W-1:0] dv,
    output logic [MAX_W-1:0] rem_out,
    output logic             q_bit
);
    logic [MAX_W:0] trial;
    logic [MAX_W:0] diff;

    always_comb begin
        trial   = {rem_in, bit_in};
        diff    = trial - {1'b0, dv};
        q_bit   = (trial >= {1'b0, dv});
        rem_out = q_bit ? diff[MAX_W-1:0] : trial[MAX_W-1:0];
    end
endmodule

// File: rtl/udiv_multi.sv
module udiv_multi
    import udiv_pkg::*;
#(
    parameter int unsigned MAX_W     = 32,
    parameter int unsigned SETUP_CYC = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [1:0]        size_sel,
    input  logic [MAX_W-1:0]  dvd_hi,
    input  logic [MAX_W-1:0]  dvd_lo,
    input  logic [MAX_W-1:0]  divisor,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic [MAX_W-1:0]  quotient,
    output logic [MAX_W-1:0]  remainder
);
    localparam int unsigned CNT_W = $clog2(MAX_W + SETUP_CYC);

    typedef struct packed {
        logic             busy;
        logic             done;
        logic             err;
        logic [CNT_W-1:0] cnt;
        size_e            sz;
        logic [MAX_W-1:0] rem;
        logic [MAX_W-1:0] sh;
        logic [MAX_W-1:0] dv;
        logic [MAX_W-1:0] quo;
        logic [MAX_W-1:0] rmd;
    } state_t;

    state_t s_d, s_q;

    size_e            in_sz;
    logic [MAX_W-1:0] hi_m, lo_m, dv_m;
    logic             ovf;
    logic             sh_msb;
    logic [MAX_W-1:0] rem_nx;
    logic             q_bit;
    logic [MAX_W-1:0] mask_q;
    logic [CNT_W-1:0] width_q;

    assign in_sz = size_e'(size_sel);

    udiv_operand #(.MAX_W(MAX_W)) u_operand (
        .sz     (in_sz),
        .hi_in  (dvd_hi),
        .lo_in  (dvd_lo),
        .dv_in  (divisor),
        .hi_out (hi_m),
        .lo_out (lo_m),
        .dv_out (dv_m)
    );

    udiv_ovf #(.MAX_W(MAX_W)) u_ovf (
        .hi  (hi_m),
        .dv  (dv_m),
        .ovf (ovf)
    );

    udiv_step #(.MAX_W(MAX_W)) u_step (
        .rem_in  (s_q.rem),
        .bit_in  (sh_msb),
        .dv      (s_q.dv),
        .rem_out (rem_nx),
        .q_bit   (q_bit)
    );

    // top in-size bit of the dividend/quotient shift register
    always_comb begin
        case (s_q.sz)
            SZ_BYTE: sh_msb = s_q.sh[BYTE_W-1];
            SZ_WORD: sh_msb = s_q.sh[WORD_W-1];
            default: sh_msb = s_q.sh[DWORD_W-1];
        endcase
        width_q = CNT_W'(size_width(s_q.sz));
        mask_q  = {MAX_W{1'b1}} >> (MAX_W - size_width(s_q.sz));
    end

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        s_d.err  = 1'b0;
        if (!s_q.busy) begin
            if (start) begin
                if (ovf) begin
                    s_d.done = 1'b1;
                    s_d.err  = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.cnt  = CNT_W'(size_width(in_sz) + SETUP_CYC - 2);
                    s_d.sz   = in_sz;
                    s_d.rem  = hi_m;
                    s_d.sh   = lo_m;
                    s_d.dv   = dv_m;
                end
            end
        end else if (s_q.cnt == '0) begin
            s_d.busy = 1'b0;
            s_d.done = 1'b1;
            s_d.quo  = s_q.sh & mask_q;
            s_d.rmd  = s_q.rem;
        end else begin
            s_d.cnt = s_q.cnt - 1'b1;
            if (s_q.cnt <= width_q) begin
                s_d.rem = rem_nx;
                s_d.sh  = {s_q.sh[MAX_W-2:0], q_bit};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign busy      = s_q.busy;
    assign done      = s_q.done;
    assign err       = s_q.err;
    assign quotient  = s_q.quo;
    assign remainder = s_q.rmd;
endmodule

// File: rtl/udiv_multi_chk.sv
module udiv_multi_chk
    import udiv_pkg::*;
#(
    parameter int unsigned MAX_W     = 32,
    parameter int unsigned SETUP_CYC = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [1:0]        size_sel,
    input logic [MAX_W-1:0]  dvd_hi,
    input logic [MAX_W-1:0]  dvd_lo,
    input logic [MAX_W-1:0]  divisor,
    input logic              busy,
    input logic              done,
    input logic              err,
    input logic [MAX_W-1:0]  quotient,
    input logic [MAX_W-1:0]  remainder
);
    logic [2*MAX_W-1:0] c_dvd;
    logic [MAX_W-1:0]   c_dv;
    logic [5:0]         c_lat;
    logic [5:0]         cyc;
    logic [2*MAX_W-1:0] recon;
    logic [MAX_W-1:0]   msk;
    int unsigned        w;

    always_comb begin
        w     = size_width(size_e'(size_sel));
        msk   = {MAX_W{1'b1}} >> (MAX_W - w);
        recon = ({{MAX_W{1'b0}}, quotient} * {{MAX_W{1'b0}}, c_dv})
              + {{MAX_W{1'b0}}, remainder};
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_dvd <= '0;
            c_dv  <= '0;
            c_lat <= '0;
            cyc   <= '0;
        end else if (start && !busy) begin
            c_dvd <= ({{MAX_W{1'b0}}, dvd_hi & msk} << w) | {{MAX_W{1'b0}}, dvd_lo & msk};
            c_dv  <= divisor & msk;
            c_lat <= 6'(w + SETUP_CYC);
            cyc   <= 6'd1;
        end else if (cyc != 6'd0 && cyc != 6'd63) begin
            cyc <= cyc + 6'd1;
        end
    end

    // R7
    quotient_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (recon == c_dvd));

    // R7
    remainder_below_divisor_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (remainder < c_dv));

    // R8
    latency_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !err) |-> (cyc == c_lat));

    // R8
    done_not_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    // R10
    err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> done);

    // R6
    err_holds_results_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> ($stable(quotient) && $stable(remainder)));

    // R9
    busy_start_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start && !done) |=> !done || !err);
endmodule

bind udiv_multi udiv_multi_chk #(.MAX_W(MAX_W), .SETUP_CYC(SETUP_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .size_sel  (size_sel),
    .dvd_hi    (dvd_hi),
    .dvd_lo    (dvd_lo),
    .divisor   (divisor),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .quotient  (quotient),
    .remainder (remainder)
);

// File: tb/udiv_multi_tb.sv
module udiv_multi_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [1:0]  size_sel = 2'd0;
    logic [31:0] dvd_hi = '0, dvd_lo = '0, divisor = '0;
    logic        busy, done, err;
    logic [31:0] quotient, remainder;

    int checks = 0;
    int failures = 0;
    logic [31:0] prev_q = '0, prev_r = '0;

    always #4 clk = ~clk;

    udiv_multi u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .size_sel(size_sel),
        .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
        .busy(busy), .done(done), .err(err),
        .quotient(quotient), .remainder(remainder)
    );

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic void model(input int sz, input logic [31:0] hi, lo, dv,
                                  output bit e, output logic [31:0] q, output logic [31:0] r);
        int unsigned w;
        longint unsigned m, dvd, d, qq;
        w   = (sz == 0) ? 8 : (sz == 1) ? 16 : 32;
        m   = (64'd1 << w) - 64'd1;
        dvd = ((longint'(hi) & m) << w) | (longint'(lo) & m);
        d   = longint'(dv) & m;
        e = 1'b0; q = prev_q; r = prev_r;
        if (d == 0) e = 1'b1;
        else begin
            qq = dvd / d;
            if (qq > m) e = 1'b1;
            else begin
                q = 32'(qq);
                r = 32'(dvd % d);
            end
        end
    endfunction

    task automatic run_op(input int sz, input logic [31:0] hi, lo, dv, input bit intrude, input string note);
        bit e; logic [31:0] eq, er;
        int n; int lat;
        string tag;
        tag = (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
        model(sz, hi, lo, dv, e, eq, er);
        lat = e ? 1 : (((sz == 0) ? 8 : (sz == 1) ? 16 : 32) + 6);
        @(negedge clk);
        start = 1'b1; size_sel = 2'(sz); dvd_hi = hi; dvd_lo = lo; divisor = dv;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        dvd_hi = $urandom; dvd_lo = $urandom; divisor = $urandom;
        n = 1;
        if (!e) chk(busy === 1'b1, "R8 busy after start", 64'(busy), 64'd1);
        else    chk(busy === 1'b0, "R6 no busy on error", 64'(busy), 64'd0);
        while (done !== 1'b1 && n < 60) begin
            if (intrude && n == 3) begin
                start = 1'b1; size_sel = 2'd0; dvd_hi = 32'h0; dvd_lo = 32'h1; divisor = 32'h0;
            end
            @(posedge clk);
            @(negedge clk);
            if (intrude && n == 3) start = 1'b0;
            n++;
        end
        chk(n == lat, e ? {"R6 latency ", note} : {"R8 latency ", note}, 64'(n), 64'(lat));
        chk(err === e, {"R4/R5 err flag ", note}, 64'(err), 64'(e));
        chk(quotient === eq, {tag, e ? " R6 held quotient " : " quotient ", note}, 64'(quotient), 64'(eq));
        chk(remainder === er, {tag, e ? " R6 held remainder " : " remainder ", note}, 64'(remainder), 64'(er));
        if (!e) begin
            chk(remainder < (dv & ((sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF)),
                "R7 remainder below divisor", 64'(remainder), 64'(dv));
            prev_q = eq; prev_r = er;
        end
        @(posedge clk);
        @(negedge clk);
        chk(done === 1'b0 && err === 1'b0, "R10 single-cycle done", 64'({done, err}), 64'd0);
        if (intrude) begin
            repeat (40) begin
                @(posedge clk);
                @(negedge clk);
                chk(done === 1'b0, "R9 no extra done after ignored start", 64'(done), 64'd0);
            end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        chk(busy === 0 && done === 0 && err === 0, "R11 reset flags", 64'({busy, done, err}), 64'd0);
        chk(quotient === 0 && remainder === 0, "R11 reset results", 64'({quotient, remainder}), 64'd0);

        // byte with junk upper bits (R12)
        run_op(0, 32'hABCD_EF05, 32'h1234_5637, 32'h9876_540A, 0, "R12 byte junk");
        run_op(1, 32'h0000_0123, 32'h0000_4567, 32'h0000_1000, 0, "word");
        run_op(2, 32'h0000_0001, 32'h0000_0000, 32'h0000_0002, 0, "dword");
        // largest quotients: hi = dv - 1 (R5 boundary, no error)
        run_op(0, 32'h0000_00FE, 32'h0000_00FF, 32'h0000_00FF, 0, "R5 byte boundary");
        run_op(1, 32'h0000_FFFE, 32'h0000_FFFF, 32'h0000_FFFF, 0, "R5 word boundary");
        run_op(2, 32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 0, "R5 dword boundary");
        // overflow: hi == dv and hi > dv (R5)
        run_op(0, 32'h0000_0010, 32'h0000_0000, 32'h0000_0010, 0, "R5 byte equal");
        run_op(1, 32'h0000_8000, 32'h0000_0001, 32'h0000_0100, 0, "R5 word greater");
        run_op(2, 32'h0000_0003, 32'h0000_0000, 32'h0000_0003, 0, "R5 dword equal");
        // zero divisor (R4), byte zero only in-size (R12)
        run_op(0, 32'h0000_0000, 32'h0000_0005, 32'h0000_0100, 0, "R4 R12 byte in-size zero");
        run_op(1, 32'h0000_0000, 32'h0000_0005, 32'h0000_0000, 0, "R4 word zero");
        run_op(2, 32'h0000_0000, 32'h0000_0005, 32'h0000_0000, 0, "R4 dword zero");
        // size code 3 behaves as dword (R3)
        run_op(3, 32'h0000_1234, 32'h5678_9ABC, 32'h0001_0000, 0, "R3 code 3");
        // start while busy (R9)
        run_op(1, 32'h0000_0042, 32'h0000_1357, 32'h0000_0777, 1, "R9 intrude");

        for (int i = 0; i < 300; i++) begin
            int sz;
            logic [31:0] dv, hi, lo, m;
            sz = int'($urandom % 3);
            m  = (sz == 0) ? 32'hFF : (sz == 1) ? 32'hFFFF : 32'hFFFF_FFFF;
            dv = $urandom;
            if ((dv & m) == 0) dv = dv | 32'h1;
            lo = $urandom;
            if ($urandom % 8 == 0) hi = $urandom;
            else hi = ($urandom % (dv & m)) | ($urandom & ~m);
            run_op(sz, hi, lo, dv, 0, "random");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule